// File: doc/BRIEF.md
# Four-T-State CPU Cycle Aligner

This block sits between a host processor's bus interface and the memory controller. It makes every processor memory cycle begin on a fixed grid of four T-states. A free-running phase counter marks the grid. When the processor signals that it wants to start a cycle, the aligner holds `ready` low for as many T-states as are needed to reach the next grid boundary. It then pulses `launch` to start the four-T-state memory cycle on that boundary.

Waits are inserted only to line a cycle up with the grid. They never depend on memory speed. A processor that issues a new cycle exactly every four T-states therefore sees no wait states at all. After a pause of any length, the next cycle is pulled back onto the grid, so the time between launches is always a whole number of grid periods. The grid length is a parameter and must be a power of two; the default is four.

Top module: `cyc_aligner`

## Requirements
- R1: Reset puts the phase counter at 0. After that the counter advances by one on every clock and wraps from GRID-1 back to 0.
- R2: `launch` is high only in a T-state whose phase is 0.
- R3: A request accepted in a T-state of phase p launches exactly (GRID-p) mod GRID T-states later. If p is 0, it launches in the same T-state as the request.
- R4: `ready` is low in every T-state from the accepted request up to, but not including, the launch T-state. There are at most GRID-1 such T-states.
- R5: `ready` is high in the launch T-state and in the GRID-1 T-states that follow it.
- R6: A request that arrives while a cycle is waiting or in progress is ignored. It produces no extra launch and no extra wait.
- R7: Requests issued every GRID T-states, starting at phase 0, run back to back with `ready` high throughout and one launch per GRID T-states.
- R8: While reset is asserted and in the first T-state after it, `ready` is 1 and `launch` is 0 when no request is present, and `phase` is 0.
- R9: After an idle pause, a request is realigned: the distance between any two launches is a multiple of GRID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | input | 1 | Processor wants to start a memory cycle in this T-state |
| ready | output | 1 | Low while the processor must wait for alignment |
| launch | output | 1 | Memory cycle starts in this T-state |
| phase | output | $clog2(GRID) | Current position in the four-T-state grid |

## Verification
The hardest case to reach is a second request arriving inside the window the first one has opened. This can happen while the first request is still waiting for phase 0, or while its four-T-state cycle is running. Any leakage would show up as a stray launch exactly one grid period later. To reach this case, the bench places a request at every phase and then places a duplicate request one T-state later. For each phase it checks the wait length, the launch T-state, and the silent grid boundary that follows.

// File: rtl/cyc_align_pkg.sv
package cyc_align_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_BUSY
    } align_st_e;

    // T-states still to go before the next grid boundary
    function automatic int unsigned wait_states(input int unsigned ph,
                                                input int unsigned grid);
        return (grid - ph) % grid;
    endfunction

endpackage

// File: rtl/cyc_align_phase.sv
module cyc_align_phase #(
    parameter int GRID = 4,
    parameter int PH_W = $clog2(GRID)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(GRID - 1);

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + PH_W'(1);
    end
endmodule

// File: rtl/cyc_align_ctrl.sv
module cyc_align_ctrl
    import cyc_align_pkg::*;
#(
    parameter int GRID = 4,
    parameter int PH_W = $clog2(GRID)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [PH_W-1:0] phase,
    output logic            ready,
    output logic            launch
);
    localparam logic [PH_W-1:0] LAST = PH_W'(GRID - 1);

    align_st_e st_q, st_d;
    logic      at_grid;

    assign at_grid = (wait_states(32'(phase), GRID) == 0);

    always_comb begin
        st_d   = st_q;
        ready  = 1'b1;
        launch = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    if (at_grid) begin
                        launch = 1'b1;
                        st_d   = ST_BUSY;
                    end else begin
                        ready = 1'b0;
                        st_d  = ST_PEND;
                    end
                end
            end
            ST_PEND: begin
                if (at_grid) begin
                    launch = 1'b1;
                    st_d   = ST_BUSY;
                end else begin
                    ready = 1'b0;
                end
            end
            ST_BUSY: begin
                if (phase == LAST) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/cyc_aligner.sv
module cyc_aligner #(
    parameter int GRID = 4,
    parameter int PH_W = $clog2(GRID)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_req,
    output logic            ready,
    output logic            launch,
    output logic [PH_W-1:0] phase
);
    cyc_align_phase #(.GRID(GRID), .PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    cyc_align_ctrl #(.GRID(GRID), .PH_W(PH_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (cyc_req),
        .phase  (phase),
        .ready  (ready),
        .launch (launch)
    );
endmodule

// File: rtl/cyc_aligner_chk.sv
module cyc_aligner_chk #(
    parameter int GRID = 4,
    parameter int PH_W = $clog2(GRID)
) (
    input logic            clk,
    input logic            rst,
    input logic            cyc_req,
    input logic            ready,
    input logic            launch,
    input logic [PH_W-1:0] phase
);
    int unsigned low_run;
    int unsigned gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= 0;
            gap     <= 0;
        end else begin
            low_run <= ready ? 0 : low_run + 1;
            if (launch)       gap <= GRID - 1;
            else if (gap > 0) gap <= gap - 1;
        end
    end

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == $past(phase) + PH_W'(1));

    assert_launch_on_grid_R2: assert property (@(posedge clk) disable iff (rst)
        launch |-> phase == '0);

    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (rst)
        !ready |-> low_run < GRID - 1);

    assert_ready_at_launch_R5: assert property (@(posedge clk) disable iff (rst)
        launch |-> ready);

    assert_no_relaunch_R6: assert property (@(posedge clk) disable iff (rst)
        launch |-> gap == 0);

    assert_grid_ready_R7: assert property (@(posedge clk) disable iff (rst)
        phase == '0 |-> ready);

    assert_cycle_ready_R5: assert property (@(posedge clk) disable iff (rst)
        gap != 0 |-> ready && !launch);
endmodule

bind cyc_aligner cyc_aligner_chk #(.GRID(GRID), .PH_W(PH_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cyc_req (cyc_req),
    .ready   (ready),
    .launch  (launch),
    .phase   (phase)
);

// File: tb/cyc_aligner_tb.sv
module cyc_aligner_tb;
    localparam int GRID = 4;
    localparam int PH_W = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cyc_req = 1'b0;
    logic            ready;
    logic            launch;
    logic [PH_W-1:0] phase;

    int checks = 0;
    int errors = 0;
    int tcyc   = 0;

    cyc_aligner #(.GRID(GRID)) u_dut (
        .clk(clk), .rst(rst), .cyc_req(cyc_req),
        .ready(ready), .launch(launch), .phase(phase)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst) tcyc <= tcyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, tcyc);
        end
    endtask

    // request at phase p, optionally a duplicate one T-state later
    task automatic run_req(input int p, input bit dup);
        int w;
        w = (GRID - p) % GRID;
        do @(negedge clk); while ((tcyc % GRID) != p);
        for (int k = 0; k < w + GRID; k++) begin
            if (k > 0) @(negedge clk);
            cyc_req = (k == 0) || (dup && k == 1);
            #1;
            chk("R1 phase", int'(phase), (p + k) % GRID);
            chk("R4/R5 ready", int'(ready), (k < w) ? 0 : 1);
            chk("R2/R3 launch", int'(launch), (k == w) ? 1 : 0);
            if (k == w) chk("R9 grid", (p + k) % GRID, 0);
        end
        @(negedge clk);
        cyc_req = 1'b0;
        #1;
        chk("R6 no extra launch", int'(launch), 0);
        chk("R6 ready", int'(ready), 1);
    endtask

    task automatic burst(input int n);
        do @(negedge clk); while ((tcyc % GRID) != 0);
        for (int k = 0; k < n * GRID; k++) begin
            if (k > 0) @(negedge clk);
            cyc_req = ((k % GRID) == 0);
            #1;
            chk("R7 ready", int'(ready), 1);
            chk("R7 launch", int'(launch), ((k % GRID) == 0) ? 1 : 0);
        end
        @(negedge clk);
        cyc_req = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                #1;
                chk("R8 ready", int'(ready), 1);
                chk("R8 launch", int'(launch), 0);
                chk("R8 phase", int'(phase), 0);
                rst = 1'b0;
                #1;
                chk("R8 phase after", int'(phase), 0);
                chk("R8 ready after", int'(ready), 1);
                for (int d = 0; d < 2; d++)
                    for (int p = 0; p < GRID; p++) begin
                        run_req(p, d[0]);
                        repeat (p + 1) @(negedge clk);
                    end
                burst(5);
                run_req(3, 1'b0);
                burst(3);
                repeat (7) @(negedge clk);
                run_req(2, 1'b1);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule